// File: doc/BRIEF.md
# Configuration Bitstream Readout Engine

This block reads a stored configuration image out of a synchronous memory array and presents it to a downstream programmable device. The image is sent either one bit per clock on data bit 0 or one byte per clock on all eight data bits. Several images (revisions) can sit in the same array. A two-bit revision code picks one of them. The code comes either from external pins or from a value fixed at build time. The chosen revision is sampled while the output-enable/reset input is held low, and it stays fixed until the next reset.

The data pins drive only while chip enable, output-enable/reset and the configuration flag are all high and the image has not yet ended. In every other case the per-bit drive enables are zero, and the pad ring treats those bits as high impedance. In byte mode a high busy input holds the current byte. Once the last byte of the selected revision has gone out, the block stops driving and raises a chain hand-off output, so that the next memory in a cascade can take over. The system clock can also be forwarded to the target device as its configuration clock.

Top module: `cfg_stream_reader`

## Requirements
- R1: Every bit of `data_en` is 0, and `data_q` is 0, unless `chip_en`, `oe_rst` and `cfg_flag` are all 1 and the image has not ended.
- R2: While `oe_rst` is 0, the read position returns to the first byte of the selected revision. The first cycle after release presents that byte.
- R3: With `par_mode`=0 (serial), only `data_en[0]` is 1. Each byte is sent most significant bit first, one bit per active clock edge, so a byte takes eight edges.
- R4: With `par_mode`=1 (byte mode), `data_en` is all ones and `data_q` advances by one byte on each active clock edge.
- R5: In byte mode, an edge with `busy`=1 leaves the presented byte and the memory address unchanged.
- R6: With `ext_sel_en`=1, the revision comes from `rev_pins`. With `ext_sel_en`=0, it comes from the parameter `INT_REV`. Revision r starts at entry r of `REV_BASES` and is entry r of `REV_LENS` bytes long (AW-bit fields, entry 0 lowest).
- R7: A change of `rev_pins` or `ext_sel_en` while `oe_rst`=1 has no effect until the next reset.
- R8: After the edge that consumes the last byte (or the last bit of the last byte), `chain_next` is 1 and `data_en` is 0. Both stay that way until `oe_rst` goes to 0.
- R9: With `FWD_CLK`=1, `clk_out` follows `clk`.
- R10: An edge with `chip_en`=0 or `cfg_flag`=0 does not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| chip_en | input | 1 | Chip enable, active high |
| oe_rst | input | 1 | Output enable; low resets the read position |
| cfg_flag | input | 1 | Configuration flag; high allows readout |
| busy | input | 1 | Byte-mode hold request from the target |
| par_mode | input | 1 | 0 selects serial, 1 selects byte output |
| ext_sel_en | input | 1 | 1 takes the revision from the pins |
| rev_pins | input | 2 | External revision code |
| rom_addr | output | AW | Address to the synchronous memory |
| rom_data | input | DW | Memory word, valid one clock after its address |
| data_q | output | DW | Output data value |
| data_en | output | DW | Per-bit pad drive enable |
| chain_next | output | 1 | Hand-off to the next device in a cascade |
| clk_out | output | 1 | Forwarded configuration clock |

## Verification
Byte-mode streams run with `busy` held low and with `busy` toggling in an irregular pattern. Together they show whether a hold freezes the address or skips a byte. A serial run over a three-byte revision shows bit order and the eight-edge byte boundary, and it shows the end of the image landing on the last bit rather than the last byte. Runs that gate `chip_en` and `cfg_flag` separately separate "not driving" from "not advancing". A run that changes the revision pins in mid-stream, next to runs using the pins and the fixed internal code, shows where the revision is sampled.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
   typedef enum logic {
      MODE_SERIAL = 1'b0,
      MODE_BYTE   = 1'b1
   } out_mode_e;

   localparam int unsigned REV_SEL_W = 2;
   localparam int unsigned NUM_REV   = 1 << REV_SEL_W;
endpackage

// File: rtl/cfg_rev_table.sv
module cfg_rev_table
   import cfg_rd_pkg::*;
#(
   parameter int unsigned AW = 10,
   parameter logic [NUM_REV*AW-1:0] BASES = '0,
   parameter logic [NUM_REV*AW-1:0] LENS  = '1
) (
   input  logic [REV_SEL_W-1:0] sel,
   output logic [AW-1:0]        base,
   output logic [AW-1:0]        len
);
   logic [AW-1:0] base_arr [NUM_REV];
   logic [AW-1:0] len_arr  [NUM_REV];

   for (genvar r = 0; r < NUM_REV; r++) begin : g_rev
      assign base_arr[r] = BASES[r*AW +: AW];
      assign len_arr[r]  = LENS[r*AW +: AW];
      if (LENS[r*AW +: AW] == '0) begin : g_bad_len
         $error("revision length must be at least one byte");
      end
   end

   assign base = base_arr[sel];
   assign len  = len_arr[sel];
endmodule

// File: rtl/cfg_rd_ctrl.sv
module cfg_rd_ctrl #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8,
   localparam int unsigned BW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          oe_rst,
   input  logic          go,
   input  logic          par,
   input  logic          busy,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   output logic [AW-1:0] addr_nxt,
   output logic [BW-1:0] bit_q,
   output logic          done_q
);
   localparam logic [BW-1:0] TOP_BIT = BW'(DW - 1);

   logic [AW-1:0] off_q, off_nxt;
   logic [BW-1:0] bit_nxt;
   logic          done_nxt, run, step, last;

   always_comb begin
      run      = go & ~done_q;
      last     = (off_q == len - AW'(1));
      step     = run & (par ? ~busy : (bit_q == '0));
      off_nxt  = off_q;
      bit_nxt  = bit_q;
      done_nxt = done_q;
      if (!oe_rst) begin
         off_nxt  = '0;
         bit_nxt  = TOP_BIT;
         done_nxt = 1'b0;
      end else begin
         if (run && !par) begin
            bit_nxt = (bit_q == '0) ? TOP_BIT : bit_q - BW'(1);
         end
         if (step) begin
            if (last) done_nxt = 1'b1;
            else      off_nxt  = off_q + AW'(1);
         end
      end
      addr_nxt = base + off_nxt;
   end

   always_ff @(posedge clk) begin
      off_q  <= off_nxt;
      bit_q  <= bit_nxt;
      done_q <= done_nxt;
   end
endmodule

// File: rtl/cfg_out_drive.sv
module cfg_out_drive #(
   parameter int unsigned DW      = 8,
   parameter bit          FWD_CLK = 1'b1,
   localparam int unsigned BW     = $clog2(DW)
) (
   input  logic          clk,
   input  logic          drive,
   input  logic          par,
   input  logic [BW-1:0] bit_sel,
   input  logic [DW-1:0] word,
   output logic [DW-1:0] data_q,
   output logic [DW-1:0] data_en,
   output logic          clk_out
);
   always_comb begin
      data_q  = '0;
      data_en = '0;
      if (drive) begin
         if (par) begin
            data_q  = word;
            data_en = '1;
         end else begin
            data_q[0]  = word[bit_sel];
            data_en[0] = 1'b1;
         end
      end
   end

   if (FWD_CLK) begin : g_fwd
      assign clk_out = clk;
   end else begin : g_nofwd
      assign clk_out = 1'b0;
   end
endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
   import cfg_rd_pkg::*;
#(
   parameter int unsigned AW      = 10,
   parameter int unsigned DW      = 8,
   parameter bit          FWD_CLK = 1'b1,
   parameter logic [REV_SEL_W-1:0]  INT_REV   = 2'd1,
   parameter logic [NUM_REV*AW-1:0] REV_BASES = {10'd48, 10'd32, 10'd16, 10'd0},
   parameter logic [NUM_REV*AW-1:0] REV_LENS  = {10'd2, 10'd5, 10'd3, 10'd4}
) (
   input  logic                 clk,
   input  logic                 chip_en,
   input  logic                 oe_rst,
   input  logic                 cfg_flag,
   input  logic                 busy,
   input  logic                 par_mode,
   input  logic                 ext_sel_en,
   input  logic [REV_SEL_W-1:0] rev_pins,
   output logic [AW-1:0]        rom_addr,
   input  logic [DW-1:0]        rom_data,
   output logic [DW-1:0]        data_q,
   output logic [DW-1:0]        data_en,
   output logic                 chain_next,
   output logic                 clk_out
);
   localparam int unsigned BW = $clog2(DW);

   if (DW != 8) begin : g_bad_dw
      $error("data width must be eight");
   end
   if (AW < 2) begin : g_bad_aw
      $error("address width too small");
   end

   logic [REV_SEL_W-1:0] rev_live, rev_q, rev_use;
   logic [AW-1:0]        base, len;
   logic [BW-1:0]        bit_sel;
   logic                 done;
   out_mode_e            mode;

   assign mode     = out_mode_e'(par_mode);
   assign rev_live = ext_sel_en ? rev_pins : INT_REV;
   assign rev_use  = oe_rst ? rev_q : rev_live;

   always_ff @(posedge clk) begin
      if (!oe_rst) rev_q <= rev_live;
   end

   cfg_rev_table #(.AW(AW), .BASES(REV_BASES), .LENS(REV_LENS)) u_tab (
      .sel  (rev_use),
      .base (base),
      .len  (len)
   );

   cfg_rd_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
      .clk      (clk),
      .oe_rst   (oe_rst),
      .go       (chip_en & cfg_flag),
      .par      (mode == MODE_BYTE),
      .busy     (busy),
      .base     (base),
      .len      (len),
      .addr_nxt (rom_addr),
      .bit_q    (bit_sel),
      .done_q   (done)
   );

   cfg_out_drive #(.DW(DW), .FWD_CLK(FWD_CLK)) u_out (
      .clk     (clk),
      .drive   (oe_rst & chip_en & cfg_flag & ~done),
      .par     (mode == MODE_BYTE),
      .bit_sel (bit_sel),
      .word    (rom_data),
      .data_q  (data_q),
      .data_en (data_en),
      .clk_out (clk_out)
   );

   assign chain_next = oe_rst & done;
endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          chip_en,
   input logic          oe_rst,
   input logic          cfg_flag,
   input logic          busy,
   input logic          par_mode,
   input logic [AW-1:0] rom_addr,
   input logic [DW-1:0] data_en,
   input logic          chain_next
);
   logic warm = 1'b0;
   always_ff @(posedge clk) warm <= 1'b1;

   assert_gate_off_R1: assert property (@(posedge clk) disable iff (!oe_rst)
      !(chip_en && cfg_flag) |-> data_en == '0);

   assert_serial_pin_R3: assert property (@(posedge clk) disable iff (!oe_rst)
      !par_mode |-> data_en[DW-1:1] == '0);

   assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!oe_rst)
      (warm && par_mode && busy) |-> rom_addr == $past(rom_addr));

   assert_chain_sticky_R8: assert property (@(posedge clk) disable iff (!oe_rst)
      chain_next |=> chain_next);

   assert_chain_quiet_R8: assert property (@(posedge clk) disable iff (!oe_rst)
      chain_next |-> data_en == '0);
endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .chip_en    (chip_en),
   .oe_rst     (oe_rst),
   .cfg_flag   (cfg_flag),
   .busy       (busy),
   .par_mode   (par_mode),
   .rom_addr   (rom_addr),
   .data_en    (data_en),
   .chain_next (chain_next)
);

// File: tb/test_cfg_stream_reader.sv
module test_cfg_stream_reader;
   localparam int AW = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          chip_en = 1'b1, oe_rst = 1'b0, cfg_flag = 1'b1, busy = 1'b0;
   logic          par_mode = 1'b1, ext_sel_en = 1'b1;
   logic [1:0]    rev_pins = 2'd0;
   logic [AW-1:0] rom_addr;
   logic [DW-1:0] rom_data, data_q, data_en;
   logic          chain_next, clk_out;

   cfg_stream_reader i_cfg_stream_reader (
      .clk(clk), .chip_en(chip_en), .oe_rst(oe_rst), .cfg_flag(cfg_flag),
      .busy(busy), .par_mode(par_mode), .ext_sel_en(ext_sel_en),
      .rev_pins(rev_pins), .rom_addr(rom_addr), .rom_data(rom_data),
      .data_q(data_q), .data_en(data_en), .chain_next(chain_next),
      .clk_out(clk_out)
   );

   function automatic logic [7:0] rom_fn(input int a);
      return 8'((a * 29 + 7) ^ (a >> 2));
   endfunction

   always @(posedge clk) rom_data <= rom_fn(int'(rom_addr));

   // behavioural reference
   int rev_base[4] = '{0, 16, 32, 48};
   int rev_len[4]  = '{4, 3, 5, 2};
   int m_off = 0, m_bit = 7, m_done = 0, m_rev = 0;

   always @(posedge clk) begin
      if (!oe_rst) begin
         m_rev  = ext_sel_en ? int'(rev_pins) : 1;
         m_off  = 0;
         m_bit  = 7;
         m_done = 0;
      end else if (chip_en && cfg_flag && m_done == 0) begin
         if (par_mode) begin
            if (!busy) begin
               if (m_off == rev_len[m_rev] - 1) m_done = 1;
               else m_off++;
            end
         end else if (m_bit == 0) begin
            m_bit = 7;
            if (m_off == rev_len[m_rev] - 1) m_done = 1;
            else m_off++;
         end else begin
            m_bit--;
         end
      end
   end

   int total = 0, bad = 0;
   bit chk_on = 1'b0;
   bit finished = 1'b0;
   string cur_req = "R1";

   always @(negedge clk) begin
      if (chk_on) begin
         logic drv;
         logic [7:0] word, e_q, e_en;
         logic e_chain;
         drv   = chip_en && oe_rst && cfg_flag && m_done == 0;
         word  = rom_fn(rev_base[m_rev] + m_off);
         e_q   = '0;
         e_en  = '0;
         if (drv) begin
            if (par_mode) begin
               e_q = word; e_en = 8'hFF;
            end else begin
               e_q[0] = word[m_bit]; e_en = 8'h01;
            end
         end
         e_chain = oe_rst && m_done != 0;
         total++;
         if (data_q !== e_q || data_en !== e_en || chain_next !== e_chain) begin
            bad++;
            $display("FAIL %s: got q=%h en=%h chain=%b expected q=%h en=%h chain=%b",
                     cur_req, data_q, data_en, chain_next, e_q, e_en, e_chain);
         end
      end
   end

   task automatic cycles(input int n, input string req);
      cur_req = req;
      repeat (n) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      finish_run();
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk); #1;
      chk_on = 1'b1;
      // reset state: nothing driven, no hand-off
      cycles(2, "R1");
      // byte mode, revision 0 from pins
      oe_rst = 1'b1;
      cycles(1, "R2");
      cycles(3, "R4");
      cycles(3, "R8");
      // byte mode with busy pattern, revision 2
      oe_rst = 1'b0; rev_pins = 2'd2;
      cycles(1, "R1");
      oe_rst = 1'b1;
      for (int i = 0; i < 12; i++) begin
         busy = (i % 3 == 1) || (i == 5);
         cycles(1, "R5");
      end
      busy = 1'b0;
      cycles(2, "R8");
      // serial, internal revision (1)
      oe_rst = 1'b0; ext_sel_en = 1'b0; rev_pins = 2'd3; par_mode = 1'b0;
      cycles(1, "R6");
      oe_rst = 1'b1;
      cycles(20, "R3");
      cycles(4, "R6");
      cycles(3, "R8");
      // revision change mid-stream is ignored
      oe_rst = 1'b0; ext_sel_en = 1'b1; rev_pins = 2'd3; par_mode = 1'b1;
      cycles(1, "R7");
      oe_rst = 1'b1;
      cycles(1, "R7");
      rev_pins = 2'd0; ext_sel_en = 1'b0;
      cycles(3, "R7");
      // enable gating
      oe_rst = 1'b0; ext_sel_en = 1'b1; rev_pins = 2'd2;
      cycles(1, "R2");
      oe_rst = 1'b1;
      chip_en = 1'b0;
      cycles(2, "R1");
      chip_en = 1'b1; cfg_flag = 1'b0;
      cycles(2, "R10");
      cfg_flag = 1'b1;
      cycles(6, "R10");
      // forwarded clock
      chk_on = 1'b0;
      total++;
      if (clk_out !== clk) begin
         bad++;
         $display("FAIL R9: got clk_out=%b expected %b", clk_out, clk);
      end
      @(posedge clk); #2;
      total++;
      if (clk_out !== 1'b1) begin
         bad++;
         $display("FAIL R9: got clk_out=%b expected 1", clk_out);
      end
      finish_run();
   end
endmodule